// File: doc/BRIEF.md
# VLAN Membership Table Engine

This block keeps the VLAN membership table of a small Ethernet switch and runs table operations on behalf of a host. The host reaches a handful of 16-bit registers over a simple synchronous bus: an operation register, a VID register and up to three per-port data registers. To start an operation, the host writes the operation code with the busy bit set. It then polls the operation register until the busy bit reads zero.

The engine supports three operations. Flush-all empties the table. Load-or-purge installs, updates or removes the entry named by the VID register. Get-next finds the valid entry with the next higher VID and copies it back into the registers. Get-next leaves its result in the VID register, so the host can issue get-next again without rewriting anything, and the table is then visited in ascending VID order. Each entry stores a 13-bit VID, an 8-bit database number, and a 2-bit member tag plus a 2-bit port state for every port. Load-or-purge and get-next examine one entry per clock. The table itself is a small parameterised on-chip array.

Top module: `vtab_engine`

## Requirements
- R1: After reset every register reads zero, the busy bit (operation register bit 15) is clear and the table holds no valid entry.
- R2: A write to the operation register (address 0) with bit 15 set and a known code in bits 14:12 starts an operation. The codes are flush-all = 1, load-or-purge = 3 and get-next = 4. For flush-all the busy bit then reads 1 for exactly one cycle. For the other two it reads 1 for exactly DEPTH+2 cycles.
- R3: While busy is set, writes to any register are ignored.
- R4: Load-or-purge with the valid flag set stores the VID, the per-port data and the database number. If that VID is already present, its entry is overwritten in place, and this works even when the table is full.
- R5: Load-or-purge with the valid flag clear removes the entry with that VID. If no entry has that VID, nothing changes.
- R6: Get-next picks the valid entry with the lowest VID strictly above the VID register. It writes that VID into the VID register with valid = 1, the entry's data into the data registers and its database number into the operation register. Repeating the operation walks the table in ascending order.
- R7: When no higher valid entry exists, get-next clears the valid flag. The VID field, the data registers and the database number are left unchanged.
- R8: Flush-all invalidates every entry and clears the full flag.
- R9: A load of a new VID into a full table is dropped and sets a sticky full flag (operation register bit 7). Only flush-all clears that flag.
- R10: The data register at address 2+k holds ports 4k to 4k+3. Port i uses the 4 bits starting at bit (i mod 4)*4: bits 1:0 are the member tag and bits 3:2 are the port state.
- R11: The VID register (address 1) holds VID[11:0] in bits 11:0, the valid flag in bit 12 and VID bit 12 in bit 13. Ordering uses the full 13-bit VID.
- R12: The database number is split across the operation register: bits 3:0 hold DB[3:0] and bits 11:8 hold DB[7:4]. The host writes it with the operation word and reads it back.
- R13: An operation-register write with bit 15 set and an unknown code starts nothing, and busy stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, valid the cycle after bus_re |

## Verification
Several properties are checked on every cycle: the upper bound on how long busy stays set, that register contents hold while the engine is busy, that the full flag is sticky, that the table is empty after a flush, and that each get-next candidate lies strictly above the search key. Other behaviour can only be shown by the bench's scenarios against its reference model. That covers picking the lowest higher VID, walking a table that includes page-bit VIDs, overwriting in place when the table is full, purging an absent VID, and dropping a new load into a full table.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam int VID_W = 13;
  localparam int DB_W  = 8;

  localparam logic [2:0] OPC_FLUSH = 3'd1;
  localparam logic [2:0] OPC_LOAD  = 3'd3;
  localparam logic [2:0] OPC_NEXT  = 3'd4;

  localparam logic [2:0] A_OP    = 3'd0;
  localparam logic [2:0] A_VID   = 3'd1;
  localparam int         A_DATA0 = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_FLUSH, S_SCAN, S_LAST, S_COMMIT
  } state_e;
endpackage

// File: rtl/vtab_store.sv
module vtab_store
  import vtab_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 48,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic             wvalid,
  input  logic [VID_W-1:0] wvid,
  input  logic [DB_W-1:0]  wdb,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic             rvalid,
  output logic [VID_W-1:0] rvid,
  output logic [DB_W-1:0]  rdb,
  output logic [DW-1:0]    rdata
);
  logic [DEPTH-1:0] valid_q;
  logic [VID_W-1:0] vid_mem  [DEPTH];
  logic [DB_W-1:0]  db_mem   [DEPTH];
  logic [DW-1:0]    data_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || clr_all) valid_q <= '0;
    else if (we)        valid_q[waddr] <= wvalid;
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= valid_q[raddr];
  end

  // payload arrays: no reset, synchronous read, block-RAM friendly
  always_ff @(posedge clk) begin
    if (we) begin
      vid_mem[waddr]  <= wvid;
      db_mem[waddr]   <= wdb;
      data_mem[waddr] <= wdata;
    end
    rvid  <= vid_mem[raddr];
    rdb   <= db_mem[raddr];
    rdata <= data_mem[raddr];
  end

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (valid_q == '0));
endmodule

// File: rtl/vtab_scan.sv
module vtab_scan
  import vtab_pkg::*;
#(
  parameter int DW = 48,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [VID_W-1:0] key,
  input  logic [AW-1:0]    e_idx,
  input  logic             e_valid,
  input  logic [VID_W-1:0] e_vid,
  input  logic [DB_W-1:0]  e_db,
  input  logic [DW-1:0]    e_data,
  output logic             hit,
  output logic [AW-1:0]    hit_idx,
  output logic             free_ok,
  output logic [AW-1:0]    free_idx,
  output logic             best_ok,
  output logic [VID_W-1:0] best_vid,
  output logic [DB_W-1:0]  best_db,
  output logic [DW-1:0]    best_data
);
  logic better;
  assign better = e_valid && (e_vid > key) && (!best_ok || (e_vid < best_vid));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hit <= 1'b0;  hit_idx <= '0;
      free_ok <= 1'b0; free_idx <= '0;
      best_ok <= 1'b0; best_vid <= '0; best_db <= '0; best_data <= '0;
    end else if (step) begin
      if (e_valid && (e_vid == key)) begin
        hit <= 1'b1;
        hit_idx <= e_idx;
      end
      if (!e_valid && !free_ok) begin
        free_ok <= 1'b1;
        free_idx <= e_idx;
      end
      if (better) begin
        best_ok <= 1'b1;
        best_vid <= e_vid;
        best_db <= e_db;
        best_data <= e_data;
      end
    end
  end

  p_next_above_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> (!best_ok || (best_vid > $past(key))));
  p_match_seen_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && e_valid && (e_vid == key)) |=> hit);
endmodule

// File: rtl/vtab_engine.sv
module vtab_engine
  import vtab_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PORTS = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int DW  = PORTS * 4;
  localparam int NDR = (PORTS + 3) / 4;
  localparam int CW  = $clog2(DEPTH + 4) + 1;

  function automatic logic [15:0] dmask(input int r);
    logic [15:0] m;
    m = '0;
    for (int p = 0; p < 4; p++) m[p*4 +: 4] = (r*4 + p < PORTS) ? 4'hF : 4'h0;
    return m;
  endfunction

  state_e           st;
  logic             busy_q, full_q, vval_q, cmp_live_q;
  logic [2:0]       code_q;
  logic [DB_W-1:0]  db_q;
  logic [VID_W-1:0] vid_q;
  logic [15:0]      dat_q [NDR];
  logic [AW-1:0]    idx_q, cmp_idx_q;
  logic [DW-1:0]    dat_flat;

  logic             s_valid;
  logic [VID_W-1:0] s_vid;
  logic [DB_W-1:0]  s_db;
  logic [DW-1:0]    s_data;

  logic             hit, free_ok, best_ok;
  logic [AW-1:0]    hit_idx, free_idx;
  logic [VID_W-1:0] best_vid;
  logic [DB_W-1:0]  best_db;
  logic [DW-1:0]    best_data;

  logic host_ok, known, start, t_we;
  logic [2:0] opc;

  assign opc     = bus_wdata[14:12];
  assign known   = (opc == OPC_FLUSH) || (opc == OPC_LOAD) || (opc == OPC_NEXT);
  assign host_ok = bus_we && !busy_q;
  assign start   = host_ok && (bus_addr == A_OP) && bus_wdata[15] && known;

  always_comb begin
    for (int p = 0; p < PORTS; p++) dat_flat[p*4 +: 4] = dat_q[p/4][(p%4)*4 +: 4];
  end

  assign t_we = (st == S_COMMIT) && (code_q == OPC_LOAD) &&
                (vval_q ? (hit || free_ok) : hit);

  vtab_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .clr_all(st == S_FLUSH),
    .we(t_we), .waddr(hit ? hit_idx : free_idx), .wvalid(vval_q),
    .wvid(vid_q), .wdb(db_q), .wdata(dat_flat),
    .raddr(idx_q), .rvalid(s_valid), .rvid(s_vid), .rdb(s_db), .rdata(s_data)
  );

  vtab_scan #(.DW(DW), .AW(AW)) u_scan (
    .clk(clk), .rst(rst), .clear(start), .step(cmp_live_q), .key(vid_q),
    .e_idx(cmp_idx_q), .e_valid(s_valid), .e_vid(s_vid), .e_db(s_db), .e_data(s_data),
    .hit(hit), .hit_idx(hit_idx), .free_ok(free_ok), .free_idx(free_idx),
    .best_ok(best_ok), .best_vid(best_vid), .best_db(best_db), .best_data(best_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; busy_q <= 1'b0; full_q <= 1'b0; vval_q <= 1'b0;
      code_q <= '0; db_q <= '0; vid_q <= '0;
      idx_q <= '0; cmp_idx_q <= '0; cmp_live_q <= 1'b0;
      for (int r = 0; r < NDR; r++) dat_q[r] <= '0;
    end else begin
      cmp_live_q <= (st == S_SCAN);
      cmp_idx_q  <= idx_q;
      case (st)
        S_IDLE: if (host_ok) begin
          if (bus_addr == A_OP) begin
            code_q <= opc;
            db_q   <= {bus_wdata[11:8], bus_wdata[3:0]};
            if (start) begin
              busy_q <= 1'b1;
              idx_q  <= '0;
              st     <= (opc == OPC_FLUSH) ? S_FLUSH : S_SCAN;
            end
          end else if (bus_addr == A_VID) begin
            vid_q  <= {bus_wdata[13], bus_wdata[11:0]};
            vval_q <= bus_wdata[12];
          end
          for (int r = 0; r < NDR; r++)
            if (bus_addr == 3'(A_DATA0 + r)) dat_q[r] <= bus_wdata & dmask(r);
        end
        S_FLUSH: begin
          full_q <= 1'b0; busy_q <= 1'b0; st <= S_IDLE;
        end
        S_SCAN: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == AW'(DEPTH - 1)) st <= S_LAST;
        end
        S_LAST: st <= S_COMMIT;
        S_COMMIT: begin
          busy_q <= 1'b0;
          st     <= S_IDLE;
          if ((code_q == OPC_LOAD) && vval_q && !hit && !free_ok) full_q <= 1'b1;
          if (code_q == OPC_NEXT) begin
            if (best_ok) begin
              vid_q  <= best_vid;
              vval_q <= 1'b1;
              db_q   <= best_db;
              for (int r = 0; r < NDR; r++) dat_q[r] <= '0;
              for (int p = 0; p < PORTS; p++)
                dat_q[p/4][(p%4)*4 +: 4] <= best_data[p*4 +: 4];
            end else begin
              vval_q <= 1'b0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) begin
      bus_rdata <= '0;
      if (bus_addr == A_OP)
        bus_rdata <= {busy_q, code_q, db_q[7:4], full_q, 3'b000, db_q[3:0]};
      else if (bus_addr == A_VID)
        bus_rdata <= {2'b00, vid_q[12], vval_q, vid_q[11:0]};
      for (int r = 0; r < NDR; r++)
        if (bus_addr == 3'(A_DATA0 + r)) bus_rdata <= dat_q[r];
    end
  end

  // busy-length watch counter
  logic [CW-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || !busy_q) busy_cnt <= '0;
    else                busy_cnt <= busy_cnt + 1'b1;
  end

  p_busy_bound_r2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (busy_cnt <= CW'(DEPTH + 2)));
  p_busy_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && bus_we && (st != S_COMMIT)) |=> ($stable(vid_q) && $stable(vval_q) && $stable(db_q)));
  p_full_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (full_q && (st != S_FLUSH)) |=> full_q);
  p_bad_code_r13: assert property (@(posedge clk) disable iff (rst)
    (host_ok && (bus_addr == A_OP) && !known) |=> !busy_q);
endmodule

// File: tb/vtab_engine_tb.sv
module vtab_engine_tb;
  localparam int DEPTH = 16;
  localparam int PORTS = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  always #2 clk = ~clk;

  vtab_engine #(.DEPTH(DEPTH), .PORTS(PORTS)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  int total = 0, bad = 0;
  bit done = 0;

  // reference model
  logic [55:0] tbl [int];
  logic [12:0] m_vid;  logic m_vv;  logic [7:0] m_db;  logic [2:0] m_code;
  logic m_full;  logic [15:0] m_dat [3];

  task automatic chk(string rq, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check_regs(string rq);
    logic [15:0] v;
    rd(3'd0, v); chk({rq, " op"}, v, {1'b0, m_code, m_db[7:4], m_full, 3'b000, m_db[3:0]});
    rd(3'd1, v); chk({rq, " vid"}, v, {2'b00, m_vid[12], m_vv, m_vid[11:0]});
    for (int r = 0; r < 3; r++) begin
      rd(3'(2 + r), v); chk({rq, " data"}, v, m_dat[r]);
    end
  endtask

  task automatic set_vid(logic [12:0] v, logic val);
    wr(3'd1, {2'b00, v[12], val, v[11:0]});
    m_vid = v; m_vv = val;
  endtask

  task automatic set_data(logic [47:0] d);
    for (int r = 0; r < 3; r++) begin
      wr(3'(2 + r), d[r*16 +: 16]);
      m_dat[r] = d[r*16 +: 16];
    end
  endtask

  task automatic model_apply(logic [2:0] c);
    if (c == 3'd1) begin
      tbl.delete(); m_full = 1'b0;
    end else if (c == 3'd3) begin
      if (m_vv) begin
        if (tbl.exists(int'(m_vid)) || tbl.size() < DEPTH)
          tbl[int'(m_vid)] = {m_db, m_dat[2], m_dat[1], m_dat[0]};
        else m_full = 1'b1;
      end else if (tbl.exists(int'(m_vid))) tbl.delete(int'(m_vid));
    end else if (c == 3'd4) begin
      int k; bit found = 0;
      if (tbl.first(k)) begin
        do begin
          if (!found && k > int'(m_vid)) begin
            found = 1;
            m_vid = 13'(k); m_vv = 1'b1;
            {m_db, m_dat[2], m_dat[1], m_dat[0]} = tbl[k];
          end
        end while (tbl.next(k));
      end
      if (!found) m_vv = 1'b0;
    end
  endtask

  // issue op, poll busy, compare busy length, then update model
  task automatic run_op(logic [2:0] c, logic [7:0] db, int skip, string rq);
    logic [15:0] v; int cnt = 0; int exp;
    wr(3'd0, {1'b1, c, db[7:4], 4'b0000, db[3:0]});
    m_code = c; m_db = db;
    exp = (c == 3'd1) ? 1 : ((c == 3'd3 || c == 3'd4) ? DEPTH + 2 : 0);
    if (exp > 0) exp = exp - skip;
    for (int i = 0; i < 100; i++) begin
      rd(3'd0, v);
      if (v[15]) cnt++;
      else break;
    end
    chk({rq, " busy-length"}, 16'(cnt), 16'(exp));
    if (exp > 0 || c == 3'd1) model_apply(c);
  endtask

  task automatic load(logic [12:0] v, logic [7:0] db, logic [47:0] d, string rq);
    set_vid(v, 1'b1); set_data(d); run_op(3'd3, db, 0, rq);
  endtask

  task automatic next_from(logic [12:0] v, string rq);
    set_vid(v, 1'b0); run_op(3'd4, 8'h00, 0, rq); check_regs(rq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_vid = '0; m_vv = 0; m_db = '0; m_code = '0; m_full = 0;
    for (int r = 0; r < 3; r++) m_dat[r] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    check_regs("R1 reset");
    next_from(13'd0, "R1 R7 empty next");

    load(13'd100,   8'h12, 48'h0000_0000_3210, "R4 R12 load100");
    load(13'd5,     8'hA5, 48'hFFFF_0000_000F, "R4 R10 load5");
    load(13'h1ABC,  8'h7E, 48'h1234_5678_9ABC, "R11 load page");
    load(13'd40,    8'h03, 48'h0001_0020_0300, "R4 load40");

    next_from(13'd0, "R6 walk");
    for (int i = 0; i < 4; i++) begin
      run_op(3'd4, 8'h00, 0, "R6 R10 R11 R12 walk step");
      check_regs("R6 walk step");
    end

    load(13'd40, 8'h44, 48'h4444_3333_2222, "R4 overwrite");
    next_from(13'd39, "R4 in-place");
    run_op(3'd4, 8'h00, 0, "R4 after40"); check_regs("R4 after40");

    set_vid(13'd100, 1'b0); run_op(3'd3, 8'h00, 0, "R5 purge");
    set_vid(13'd77, 1'b0);  run_op(3'd3, 8'h00, 0, "R5 purge absent");
    next_from(13'd41, "R5 gone");

    // R3: writes during busy are ignored
    set_vid(13'd4, 1'b0);
    wr(3'd0, {1'b1, 3'd4, 4'h0, 4'h0, 4'h0});
    m_code = 3'd4; m_db = 8'h00;
    wr(3'd1, 16'h1FFF);
    wr(3'd2, 16'hDEAD);
    begin
      logic [15:0] v; int cnt = 0;
      for (int i = 0; i < 100; i++) begin
        rd(3'd0, v); if (v[15]) cnt++; else break;
      end
      chk("R3 busy-length", 16'(cnt), 16'(DEPTH));
    end
    model_apply(3'd4);
    check_regs("R3 busy writes");

    // R13: unknown code
    run_op(3'd6, 8'h5A, 0, "R13 unknown");
    check_regs("R13 unknown");

    // R9: fill to full, then drop a new VID
    for (int j = 0; j < DEPTH; j++)
      if (tbl.size() < DEPTH) load(13'(200 + j), 8'(j), 48'(j * 3), "R9 fill");
    load(13'd999, 8'hEE, 48'h1, "R9 full drop");
    check_regs("R9 full flag");
    next_from(13'd998, "R9 dropped");
    load(13'd5, 8'h99, 48'h0ABC_0DEF_0123, "R4 overwrite when full");
    next_from(13'd4, "R4 full overwrite");

    run_op(3'd1, 8'h00, 0, "R8 flush");
    check_regs("R8 flush");
    next_from(13'd0, "R8 empty");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule